// File: doc/BRIEF.md
# Byte-Masked Cache Line Merge Buffer

This block holds a single cache line together with a per-byte dirty mask. A separate controller makes every coherence decision and drives it through command strobes. The block only carries out the data side of those decisions. Partial-line writes arrive with a byte-enable mask, and only the enabled bytes are merged into the stored line. A full-line fill from memory replaces the data without touching the dirty record.

The dirty mask is sticky. It gathers the union of every partial-write mask since the last allocation and is cleared only by allocation. When the controller asks for a writeback, the block produces one outbound message. That message carries the whole stored line, the gathered mask and a dirty marker, so that memory updates only the bytes that were written. A pass-through write-through uses the same outbound port but forwards the requester's own data and mask instead of the stored line.

Outbound messages are registered and appear in the cycle after the command. A fill and a partial write in the same cycle is a controller error. The block raises an error flag for that case and lets the fill win.

Top module: `line_merge_buf`

## Requirements
- R1: After reset the stored line and the dirty mask are all zeros, and out_vld_o and err_o are low.
- R2: alloc_i clears the dirty mask to all zeros from the next cycle and leaves the stored line data unchanged. When alloc_i and a partial write occur in the same cycle, the clear happens first, so the mask becomes the incoming mask.
- R3: A partial write (wr_i) replaces byte i of the stored line (bits 8i+7 down to 8i) with the same byte of wr_data_i when bit i of wr_mask_i is 1. Every byte whose mask bit is 0 keeps its value.
- R4: Outside an allocation, a partial write sets the dirty mask to the bitwise OR of its previous value and wr_mask_i. A write with an all-zero mask changes neither the line nor the mask.
- R5: A fill (fill_i) overwrites all 64 bytes with fill_data_i and leaves the dirty mask unchanged.
- R6: In the cycle after wb_i, out_vld_o=1, out_src_o=0 and out_dirty_o=1. out_data_o and out_mask_o hold the line and mask as they were in the wb_i cycle, before any update made in that same cycle.
- R7: In the cycle after pt_i (with wb_i low), out_vld_o=1, out_src_o=1 and out_dirty_o=1. out_data_o and out_mask_o hold the wr_data_i and wr_mask_i of the pt_i cycle.
- R8: When wb_i and pt_i are both high, the writeback wins and the outbound message has out_src_o=0.
- R9: When wr_i and fill_i are both high, err_o is 1 in the next cycle, the line takes fill_data_i and the partial write is dropped from both the line and the mask. err_o is 0 in every other cycle after reset.
- R10: In a cycle after one with neither wb_i nor pt_i, out_vld_o and out_dirty_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_i | input | 1 | Allocate: clear the dirty mask |
| wr_i | input | 1 | Partial write strobe |
| wr_data_i | input | 512 | Write data for a partial write or pass-through |
| wr_mask_i | input | 64 | Byte enables for a partial write or pass-through |
| fill_i | input | 1 | Full-line fill strobe |
| fill_data_i | input | 512 | Fill data from memory |
| wb_i | input | 1 | Emit a writeback of the stored line |
| pt_i | input | 1 | Emit a pass-through write-through |
| line_o | output | 512 | Stored line |
| dmask_o | output | 64 | Accumulated dirty byte mask |
| out_vld_o | output | 1 | Outbound message valid |
| out_src_o | output | 1 | Outbound source: 0 stored line, 1 pass-through |
| out_dirty_o | output | 1 | Outbound dirty marker |
| out_data_o | output | 512 | Outbound line data |
| out_mask_o | output | 64 | Outbound byte mask |
| err_o | output | 1 | Fill and partial-write collision seen last cycle |

## Verification
The merge is tried with several mask shapes:
- A low nibble of bytes, a mask that reaches both ends of the line and overlaps an earlier write, an all-ones mask, an all-zero mask and a single top byte. Together these separate a correct per-byte select from swapped byte order, off-by-one lane mapping, and an update that ignores the mask.
- Writebacks taken after fills, after allocations and after overlapping writes. These show that the mask is a sticky union and survives fills, rather than being a copy of the last write.
- Combined strobes: writeback with pass-through, write with fill, allocate with write, and writeback with allocate. These pin down each priority and show that emits sample the pre-update state.

// File: rtl/lmb_pkg.sv
package lmb_pkg;

    localparam int LMB_NBYTES = 64;
    localparam int LMB_BYTE_W = 8;

    typedef enum logic {
        SRC_LINE = 1'b0,
        SRC_PASS = 1'b1
    } emit_src_e;

    typedef struct packed {
        logic      alloc;
        logic      write;
        logic      fill;
        logic      emit;
        emit_src_e src;
        logic      clash;
    } cmd_t;

    function automatic emit_src_e pick_src(input logic wb, input logic pt);
        emit_src_e s;
        s = SRC_LINE;
        if (!wb && pt) begin
            s = SRC_PASS;
        end
        return s;
    endfunction

endpackage

// File: rtl/lmb_cmd_arb.sv
module lmb_cmd_arb
    import lmb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic alloc_i,
    input  logic wr_i,
    input  logic fill_i,
    input  logic wb_i,
    input  logic pt_i,
    output cmd_t cmd_o,
    output logic err_o
);

    always_comb begin
        cmd_o.alloc = alloc_i;
        cmd_o.fill  = fill_i;
        cmd_o.write = wr_i & ~fill_i;
        cmd_o.emit  = wb_i | pt_i;
        cmd_o.src   = pick_src(wb_i, pt_i);
        cmd_o.clash = wr_i & fill_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_o <= 1'b0;
        end else begin
            err_o <= cmd_o.clash;
        end
    end

endmodule

// File: rtl/lmb_line_store.sv
module lmb_line_store
    import lmb_pkg::*;
#(
    parameter int NBYTES = LMB_NBYTES,
    parameter int BYTE_W = LMB_BYTE_W,
    localparam int LINE_W = NBYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  cmd_t              cmd_i,
    input  logic [LINE_W-1:0] wr_data_i,
    input  logic [NBYTES-1:0] wr_mask_i,
    input  logic [LINE_W-1:0] fill_data_i,
    output logic [LINE_W-1:0] line_o,
    output logic [NBYTES-1:0] dmask_o
);

    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        logic take_wr;
        assign take_wr = cmd_i.write & wr_mask_i[b];

        always_ff @(posedge clk) begin
            if (rst) begin
                line_o[b*BYTE_W +: BYTE_W] <= '0;
            end else if (cmd_i.fill) begin
                line_o[b*BYTE_W +: BYTE_W] <= fill_data_i[b*BYTE_W +: BYTE_W];
            end else if (take_wr) begin
                line_o[b*BYTE_W +: BYTE_W] <= wr_data_i[b*BYTE_W +: BYTE_W];
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                dmask_o[b] <= 1'b0;
            end else if (cmd_i.alloc) begin
                dmask_o[b] <= take_wr;
            end else if (take_wr) begin
                dmask_o[b] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/lmb_emit_reg.sv
module lmb_emit_reg
    import lmb_pkg::*;
#(
    parameter int NBYTES = LMB_NBYTES,
    parameter int BYTE_W = LMB_BYTE_W,
    localparam int LINE_W = NBYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  cmd_t              cmd_i,
    input  logic [LINE_W-1:0] line_i,
    input  logic [NBYTES-1:0] dmask_i,
    input  logic [LINE_W-1:0] req_data_i,
    input  logic [NBYTES-1:0] req_mask_i,
    output logic              vld_o,
    output logic              src_o,
    output logic              dirty_o,
    output logic [LINE_W-1:0] data_o,
    output logic [NBYTES-1:0] mask_o
);

    logic [LINE_W-1:0] sel_data;
    logic [NBYTES-1:0] sel_mask;

    always_comb begin
        if (cmd_i.src == SRC_PASS) begin
            sel_data = req_data_i;
            sel_mask = req_mask_i;
        end else begin
            sel_data = line_i;
            sel_mask = dmask_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_o   <= 1'b0;
            src_o   <= 1'b0;
            dirty_o <= 1'b0;
            data_o  <= '0;
            mask_o  <= '0;
        end else begin
            vld_o   <= cmd_i.emit;
            dirty_o <= cmd_i.emit;
            if (cmd_i.emit) begin
                src_o  <= cmd_i.src;
                data_o <= sel_data;
                mask_o <= sel_mask;
            end
        end
    end

endmodule

// File: rtl/line_merge_buf.sv
module line_merge_buf
    import lmb_pkg::*;
#(
    parameter int NBYTES = LMB_NBYTES,
    parameter int BYTE_W = LMB_BYTE_W,
    localparam int LINE_W = NBYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_i,
    input  logic              wr_i,
    input  logic [LINE_W-1:0] wr_data_i,
    input  logic [NBYTES-1:0] wr_mask_i,
    input  logic              fill_i,
    input  logic [LINE_W-1:0] fill_data_i,
    input  logic              wb_i,
    input  logic              pt_i,
    output logic [LINE_W-1:0] line_o,
    output logic [NBYTES-1:0] dmask_o,
    output logic              out_vld_o,
    output logic              out_src_o,
    output logic              out_dirty_o,
    output logic [LINE_W-1:0] out_data_o,
    output logic [NBYTES-1:0] out_mask_o,
    output logic              err_o
);

    cmd_t cmd;

    lmb_cmd_arb u_arb (
        .clk     (clk),
        .rst     (rst),
        .alloc_i (alloc_i),
        .wr_i    (wr_i),
        .fill_i  (fill_i),
        .wb_i    (wb_i),
        .pt_i    (pt_i),
        .cmd_o   (cmd),
        .err_o   (err_o)
    );

    lmb_line_store #(.NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_store (
        .clk         (clk),
        .rst         (rst),
        .cmd_i       (cmd),
        .wr_data_i   (wr_data_i),
        .wr_mask_i   (wr_mask_i),
        .fill_data_i (fill_data_i),
        .line_o      (line_o),
        .dmask_o     (dmask_o)
    );

    lmb_emit_reg #(.NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_emit (
        .clk        (clk),
        .rst        (rst),
        .cmd_i      (cmd),
        .line_i     (line_o),
        .dmask_i    (dmask_o),
        .req_data_i (wr_data_i),
        .req_mask_i (wr_mask_i),
        .vld_o      (out_vld_o),
        .src_o      (out_src_o),
        .dirty_o    (out_dirty_o),
        .data_o     (out_data_o),
        .mask_o     (out_mask_o)
    );

endmodule

// File: rtl/lmb_checker.sv
module lmb_checker #(
    parameter int NBYTES = 64,
    parameter int BYTE_W = 8,
    localparam int LINE_W = NBYTES * BYTE_W
) (
    input logic              clk,
    input logic              rst,
    input logic              alloc_i,
    input logic              wr_i,
    input logic [LINE_W-1:0] wr_data_i,
    input logic [NBYTES-1:0] wr_mask_i,
    input logic              fill_i,
    input logic [LINE_W-1:0] fill_data_i,
    input logic              wb_i,
    input logic              pt_i,
    input logic [LINE_W-1:0] line_o,
    input logic [NBYTES-1:0] dmask_o,
    input logic              out_vld_o,
    input logic              out_src_o,
    input logic              out_dirty_o,
    input logic [LINE_W-1:0] out_data_o,
    input logic [NBYTES-1:0] out_mask_o,
    input logic              err_o
);

    function automatic logic [LINE_W-1:0] widen(input logic [NBYTES-1:0] m);
        logic [LINE_W-1:0] r;
        for (int i = 0; i < NBYTES; i++) begin
            r[i*BYTE_W +: BYTE_W] = {BYTE_W{m[i]}};
        end
        return r;
    endfunction

    a_r2_alloc_clears: assert property (@(posedge clk) disable iff (rst)
        (alloc_i && !wr_i) |=> (dmask_o == '0 && line_o == $past(line_o)));

    a_r3_enabled_bytes_taken: assert property (@(posedge clk) disable iff (rst)
        (wr_i && !fill_i) |=> (((line_o ^ $past(wr_data_i)) & widen($past(wr_mask_i))) == '0));

    a_r3_other_bytes_kept: assert property (@(posedge clk) disable iff (rst)
        (wr_i && !fill_i) |=> (((line_o ^ $past(line_o)) & ~widen($past(wr_mask_i))) == '0));

    a_r4_mask_union: assert property (@(posedge clk) disable iff (rst)
        (wr_i && !fill_i && !alloc_i) |=> (dmask_o == ($past(dmask_o) | $past(wr_mask_i))));

    a_r5_fill_keeps_mask: assert property (@(posedge clk) disable iff (rst)
        (fill_i && !alloc_i) |=> (line_o == $past(fill_data_i) && dmask_o == $past(dmask_o)));

    a_r6_writeback_msg: assert property (@(posedge clk) disable iff (rst)
        wb_i |=> (out_vld_o && out_dirty_o && !out_src_o &&
                  out_data_o == $past(line_o) && out_mask_o == $past(dmask_o)));

    a_r7_passthrough_msg: assert property (@(posedge clk) disable iff (rst)
        (pt_i && !wb_i) |=> (out_vld_o && out_dirty_o && out_src_o &&
                             out_data_o == $past(wr_data_i) && out_mask_o == $past(wr_mask_i)));

    a_r9_clash_flag: assert property (@(posedge clk) disable iff (rst)
        (wr_i && fill_i) |=> err_o);

    a_r9_no_false_flag: assert property (@(posedge clk) disable iff (rst)
        !(wr_i && fill_i) |=> !err_o);

    a_r10_quiet_outbound: assert property (@(posedge clk) disable iff (rst)
        (!wb_i && !pt_i) |=> (!out_vld_o && !out_dirty_o));

endmodule

bind line_merge_buf lmb_checker #(.NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_chk (.*);

// File: tb/sim_line_merge_buf.sv
`timescale 1ns/1ps
module sim_line_merge_buf;

    localparam int NB = 64;
    localparam int LW = NB * 8;

    typedef struct packed {
        logic        al;
        logic        wr;
        logic        fl;
        logic        wb;
        logic        pt;
        logic [7:0]  seed;
        logic [63:0] mask;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0,   64'h0},
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd11,  64'h0000_0000_0000_000F},
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd22,  64'hF000_0000_0000_0001},
        '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'd0,   64'h0},
        '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'd33,  64'h0},
        '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'd0,   64'h0},
        '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'd44,  64'h00FF_0000_FF00_0000},
        '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'd55,  64'h1234_5678_9ABC_DEF0},
        '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'd66,  64'hFFFF_FFFF_FFFF_FFFF},
        '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0,   64'h0},
        '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'd0,   64'h0},
        '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'd77,  64'h8000_0000_0000_0000},
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd88,  64'h0},
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd99,  64'hFFFF_FFFF_FFFF_FFFF},
        '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0,   64'h0},
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'd12,  64'h0000_0000_0000_0F0F},
        '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'd0,   64'h0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic alloc_i = 1'b0, wr_i = 1'b0, fill_i = 1'b0, wb_i = 1'b0, pt_i = 1'b0;
    logic [LW-1:0] wr_data_i = '0, fill_data_i = '0;
    logic [NB-1:0] wr_mask_i = '0;
    logic [LW-1:0] line_o, out_data_o;
    logic [NB-1:0] dmask_o, out_mask_o;
    logic out_vld_o, out_src_o, out_dirty_o, err_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [LW-1:0] m_line;
    logic [NB-1:0] m_mask;

    always #2 clk = ~clk;

    line_merge_buf u0 (
        .clk(clk), .rst(rst), .alloc_i(alloc_i), .wr_i(wr_i),
        .wr_data_i(wr_data_i), .wr_mask_i(wr_mask_i), .fill_i(fill_i),
        .fill_data_i(fill_data_i), .wb_i(wb_i), .pt_i(pt_i),
        .line_o(line_o), .dmask_o(dmask_o), .out_vld_o(out_vld_o),
        .out_src_o(out_src_o), .out_dirty_o(out_dirty_o),
        .out_data_o(out_data_o), .out_mask_o(out_mask_o), .err_o(err_o)
    );

    function automatic logic [LW-1:0] pat(input logic [7:0] seed, input logic [7:0] salt);
        logic [LW-1:0] r;
        for (int i = 0; i < NB; i++) begin
            r[i*8 +: 8] = (seed ^ salt) + 8'(i * 37);
        end
        return r;
    endfunction

    task automatic chk(input string what, input logic [LW-1:0] act, input logic [LW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        logic [LW-1:0] wd, fd, e_data;
        logic [NB-1:0] e_mask;
        logic e_vld, e_src, e_err;
        wd = pat(v.seed, 8'h00);
        fd = pat(v.seed, 8'hA5);
        e_vld  = v.wb | v.pt;
        e_src  = ~v.wb;
        e_data = v.wb ? m_line : wd;
        e_mask = v.wb ? m_mask : v.mask;
        e_err  = v.wr & v.fl;
        if (v.fl) begin
            m_line = fd;
        end else if (v.wr) begin
            for (int i = 0; i < NB; i++) begin
                if (v.mask[i]) m_line[i*8 +: 8] = wd[i*8 +: 8];
            end
        end
        if (v.al) begin
            m_mask = (v.wr && !v.fl) ? v.mask : '0;
        end else if (v.wr && !v.fl) begin
            m_mask = m_mask | v.mask;
        end
        alloc_i = v.al; wr_i = v.wr; fill_i = v.fl; wb_i = v.wb; pt_i = v.pt;
        wr_data_i = wd; wr_mask_i = v.mask; fill_data_i = fd;
        @(negedge clk);
        alloc_i = 1'b0; wr_i = 1'b0; fill_i = 1'b0; wb_i = 1'b0; pt_i = 1'b0;
        chk($sformatf("v%0d line R2 R3 R5 R9", idx), line_o, m_line);
        chk($sformatf("v%0d mask R2 R4 R5 R9", idx), LW'(dmask_o), LW'(m_mask));
        chk($sformatf("v%0d err R9", idx), LW'(err_o), LW'(e_err));
        chk($sformatf("v%0d vld R6 R7 R10", idx), LW'(out_vld_o), LW'(e_vld));
        chk($sformatf("v%0d dirty R6 R7 R10", idx), LW'(out_dirty_o), LW'(e_vld));
        if (e_vld) begin
            chk($sformatf("v%0d src R6 R7 R8", idx), LW'(out_src_o), LW'(e_src));
            chk($sformatf("v%0d odata R6 R7 R8", idx), out_data_o, e_data);
            chk($sformatf("v%0d omask R6 R7 R8", idx), LW'(out_mask_o), LW'(e_mask));
        end
    endtask

    initial begin
        m_line = '0;
        m_mask = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("reset line R1", line_o, '0);
        chk("reset mask R1", LW'(dmask_o), '0);
        chk("reset vld R1", LW'(out_vld_o), '0);
        chk("reset err R1", LW'(err_o), '0);
        for (int k = 0; k < NV; k++) begin
            run_vec(VECS[k], k);
        end
        // R9: err_o drops again one idle cycle after a collision
        run_vec('{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'd5, 64'h0000_0000_0000_00FF}, 100);
        run_vec('{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0, 64'h0}, 101);
        // R6: writeback sampled in the same cycle as a fill sees the old line
        run_vec('{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'd200, 64'h0}, 102);
        // R1: mid-run reset returns to zero state
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("rerst line R1", line_o, '0);
        chk("rerst mask R1", LW'(dmask_o), '0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog R1: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule